// File: doc/BRIEF.md
# DMA Channel Enable and Command Register Bank

This block holds the per-channel control bits of a multi-channel DMA controller: a request-enable bit and an error-interrupt-enable bit for every channel, and a sticky interrupt flag and error flag for every channel. Software reaches them over a simple 32-bit register bus with byte-lane write strobes. Besides whole-word access, there is a group of byte-wide command ports. Writing a channel number to one of these ports acts on that single channel only. This lets a driver flip one channel's bit without a read-modify-write cycle that could race with another agent touching the same word.

A parameter chooses between a 32-channel layout and a 64-channel layout. The 64-channel layout adds high words for the enables and flags. It also changes the byte order of the command ports within each command word. The transfer engine raises the flags through per-channel set inputs. The block emits one-cycle per-channel strobes for interrupt clear, error clear, software start and done clear, for the engine to consume. Bus addresses are word addresses; byte offsets below are the word address times four plus the lane number, with lane k carrying data bits 8k+7 down to 8k.

Top module: `dma_chan_ctrl`

## Requirements
- R1: A byte write of channel number n to the set-request command port sets request-enable bit n on the next clock edge and changes no other bit.
- R2: A byte write of n to the clear-request command port clears request-enable bit n only.
- R3: Set and clear command ports for the error-interrupt-enable bits behave like the request ports of R1 and R2.
- R4: In the 32-channel layout the command byte offsets are: 0x18 clear error-int enable, 0x19 set error-int enable, 0x1A clear request, 0x1B set request, 0x1C clear done, 0x1D set start, 0x1E clear error flag, 0x1F clear interrupt flag.
- R5: In the 64-channel layout the byte order within each command word is reversed: 0x18 set request, 0x19 clear request, 0x1A set error-int enable, 0x1B clear error-int enable, 0x1C clear interrupt flag, 0x1D clear error flag, 0x1E set start, 0x1F clear done.
- R6: Request enables read and write as whole words at 0x0C (channels 0-31) and error-int enables at 0x14. The 64-channel layout adds channels 32-63 at 0x08 and 0x10. Each strobed byte lane writes its byte. In the 32-channel layout the high-word offsets read zero and ignore writes.
- R7: A high pulse on a channel's hardware interrupt or error set input sets its sticky flag. The flag words read at 0x24 (interrupt) and 0x2C (error), with high words at 0x20 and 0x28 in the 64-channel layout.
- R8: Writing ones to a flag word clears the flags at those bit positions; zero bits leave flags unchanged.
- R9: A clear-interrupt or clear-error command clears that channel's flag. Every clear-interrupt, clear-error, set-start and clear-done command drives the channel's strobe high for exactly the one cycle after the write.
- R10: A command whose channel number is at or above the channel count changes no bit and raises no strobe.
- R11: The command words at 0x18 and 0x1C read as zero. A write to them with more than one byte lane strobed is ignored entirely.
- R12: When a clear command or flag-word clear hits a flag in the same cycle as its hardware set, the flag ends cleared.
- R13: After reset all enables, flags and strobes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write qualifier for the current bus cycle |
| bus_addr | input | AW-2 | Word address |
| bus_be | input | 4 | Byte-lane write strobes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| hw_int_set | input | NCH | Per-channel interrupt flag set |
| hw_err_set | input | NCH | Per-channel error flag set |
| req_en | output | NCH | Request-enable bits |
| err_irq_en | output | NCH | Error-interrupt-enable bits |
| int_clr_pulse | output | NCH | Interrupt-clear strobes |
| err_clr_pulse | output | NCH | Error-clear strobes |
| start_pulse | output | NCH | Software-start strobes |
| done_clr_pulse | output | NCH | Done-clear strobes |

## Verification
Two instances, one per layout, receive the same bus traffic. Every command byte therefore lands on a different function in each, and the byte-order mapping of both layouts is told apart on every write. The command sweeps use low, boundary and out-of-range channel numbers (0, 31, 32, 63, 64, 200) to separate range rejection from bit placement. Partial-strobe word writes and multi-lane writes to the command words distinguish per-lane writes from ignored writes. Hardware flag sets collide with command clears and with flag-word clears in the same cycle to expose the priority.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

  typedef enum logic [2:0] {
    CK_EIE_OFF   = 3'd0,
    CK_EIE_ON    = 3'd1,
    CK_REQ_OFF   = 3'd2,
    CK_REQ_ON    = 3'd3,
    CK_DONE_CLR  = 3'd4,
    CK_START     = 3'd5,
    CK_ERRF_CLR  = 3'd6,
    CK_INTF_CLR  = 3'd7
  } cmd_kind_e;

  localparam int NKIND = 8;

  localparam logic [7:0] OFF_REQ_HI = 8'h08;
  localparam logic [7:0] OFF_REQ_LO = 8'h0C;
  localparam logic [7:0] OFF_EIE_HI = 8'h10;
  localparam logic [7:0] OFF_EIE_LO = 8'h14;
  localparam logic [7:0] OFF_CMD0   = 8'h18;
  localparam logic [7:0] OFF_CMD1   = 8'h1C;
  localparam logic [7:0] OFF_INT_HI = 8'h20;
  localparam logic [7:0] OFF_INT_LO = 8'h24;
  localparam logic [7:0] OFF_ERR_HI = 8'h28;
  localparam logic [7:0] OFF_ERR_LO = 8'h2C;

  function automatic logic [1:0] lane_of(input logic [3:0] be);
    logic [1:0] r;
    r = 2'd0;
    for (int b = 3; b >= 0; b--) begin
      if (be[b]) r = 2'(b);
    end
    return r;
  endfunction

  // the wide layout swaps byte order inside each command word
  function automatic logic [2:0] kind_of(input logic [2:0] idx, input logic wide);
    return wide ? (idx ^ 3'd3) : idx;
  endfunction

endpackage

// File: rtl/dcr_cmd_decode.sv
module dcr_cmd_decode
  import dcr_pkg::*;
#(
  parameter bit WIDE = 1'b1,
  parameter int NCH  = 64,
  parameter int AW   = 8
) (
  input  logic                       wr_en,
  input  logic [AW-3:0]              waddr,
  input  logic [3:0]                 be,
  input  logic [31:0]                wdata,
  output logic [NKIND-1:0][NCH-1:0]  cmd_hit
);

  logic [AW-1:0] base;
  logic          in_cmd;
  logic          fire;
  logic [1:0]    lane;
  logic [7:0]    chan;
  logic [2:0]    kind;

  assign base   = {waddr, 2'b00};
  assign in_cmd = (base == AW'(OFF_CMD0)) || (base == AW'(OFF_CMD1));
  assign fire   = wr_en && in_cmd && $onehot(be);
  assign lane   = lane_of(be);
  assign chan   = wdata[8*lane +: 8];
  assign kind   = kind_of({waddr[0], lane}, WIDE);

  // channel numbers at or above NCH match no decoder output
  for (genvar k = 0; k < NKIND; k++) begin : g_kind
    for (genvar c = 0; c < NCH; c++) begin : g_chan
      assign cmd_hit[k][c] = fire && (kind == 3'(k)) && (chan == 8'(c));
    end
  end

endmodule

// File: rtl/dcr_enable_bank.sv
module dcr_enable_bank
  import dcr_pkg::*;
#(
  parameter int          NCH    = 64,
  parameter int          AW     = 8,
  parameter logic [7:0]  LO_OFF = 8'h0C,
  parameter logic [7:0]  HI_OFF = 8'h08
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-3:0]    waddr,
  input  logic [3:0]       be,
  input  logic [31:0]      wdata,
  input  logic [NCH-1:0]   set_vec,
  input  logic [NCH-1:0]   clr_vec,
  output logic [NCH-1:0]   en_q
);

  localparam int NWORD = NCH / 32;

  logic [AW-1:0]    base;
  logic [NWORD-1:0] word_hit;
  logic [NCH-1:0]   en_d;
  logic             en_upd;

  assign base = {waddr, 2'b00};

  for (genvar w = 0; w < NWORD; w++) begin : g_word
    assign word_hit[w] = wr_en && (base == AW'((w == 0) ? LO_OFF : HI_OFF));
  end

  always_comb begin
    en_d = en_q;
    for (int w = 0; w < NWORD; w++) begin
      for (int b = 0; b < 4; b++) begin
        if (word_hit[w] && be[b]) en_d[32*w + 8*b +: 8] = wdata[8*b +: 8];
      end
    end
    en_d = (en_d | set_vec) & ~clr_vec;
  end

  assign en_upd = wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_upd) begin
      en_q <= en_d;
    end
  end

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((en_q & $past(set_vec)) == $past(set_vec))); // R1
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_vec) |=> ((en_q & $past(clr_vec)) == '0)); // R2

endmodule

// File: rtl/dcr_flag_bank.sv
module dcr_flag_bank
  import dcr_pkg::*;
#(
  parameter int          NCH    = 64,
  parameter int          AW     = 8,
  parameter logic [7:0]  LO_OFF = 8'h24,
  parameter logic [7:0]  HI_OFF = 8'h20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-3:0]    waddr,
  input  logic [3:0]       be,
  input  logic [31:0]      wdata,
  input  logic [NCH-1:0]   hw_set,
  input  logic [NCH-1:0]   clr_cmd,
  output logic [NCH-1:0]   flag_q
);

  localparam int NWORD = NCH / 32;

  logic [AW-1:0]    base;
  logic [NWORD-1:0] word_hit;
  logic [NCH-1:0]   w1c_mask;
  logic [NCH-1:0]   clr_all;
  logic [NCH-1:0]   flag_d;
  logic             flag_upd;

  assign base = {waddr, 2'b00};

  for (genvar w = 0; w < NWORD; w++) begin : g_word
    assign word_hit[w] = wr_en && (base == AW'((w == 0) ? LO_OFF : HI_OFF));
    for (genvar b = 0; b < 4; b++) begin : g_lane
      assign w1c_mask[32*w + 8*b +: 8] = (word_hit[w] && be[b]) ? wdata[8*b +: 8] : 8'h00;
    end
  end

  assign clr_all = w1c_mask | clr_cmd;

  // software clear has priority over a simultaneous hardware set
  always_comb begin
    flag_d = (flag_q | hw_set) & ~clr_all;
  end

  assign flag_upd = wr_en | (|hw_set);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else if (flag_upd) begin
      flag_q <= flag_d;
    end
  end

  AST_SW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_cmd & hw_set)) |=> ((flag_q & $past(clr_cmd & hw_set)) == '0)); // R12
  AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ((|hw_set) && !wr_en) |=> ((flag_q & $past(hw_set)) == $past(hw_set))); // R7

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dcr_pkg::*;
#(
  parameter bit WIDE_LAYOUT = 1'b1,
  parameter int AW          = 8,
  localparam int NCH        = WIDE_LAYOUT ? 64 : 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [AW-3:0]    bus_addr,
  input  logic [3:0]       bus_be,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [NCH-1:0]   hw_int_set,
  input  logic [NCH-1:0]   hw_err_set,
  output logic [NCH-1:0]   req_en,
  output logic [NCH-1:0]   err_irq_en,
  output logic [NCH-1:0]   int_clr_pulse,
  output logic [NCH-1:0]   err_clr_pulse,
  output logic [NCH-1:0]   start_pulse,
  output logic [NCH-1:0]   done_clr_pulse
);

  logic [NKIND-1:0][NCH-1:0] cmd_hit;
  logic [NCH-1:0]            int_flag;
  logic [NCH-1:0]            err_flag;
  logic [AW-1:0]             base;
  logic [63:0]               req_w, eie_w, int_w, err_w;
  logic [31:0]               rdata_d;
  logic [4*NCH-1:0]          pulse_d, pulse_q;
  logic                      pulse_upd;

  dcr_cmd_decode #(.WIDE(WIDE_LAYOUT), .NCH(NCH), .AW(AW)) u_dec (
    .wr_en   (bus_wr),
    .waddr   (bus_addr),
    .be      (bus_be),
    .wdata   (bus_wdata),
    .cmd_hit (cmd_hit)
  );

  dcr_enable_bank #(.NCH(NCH), .AW(AW), .LO_OFF(OFF_REQ_LO), .HI_OFF(OFF_REQ_HI)) u_req (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bus_wr),
    .waddr   (bus_addr),
    .be      (bus_be),
    .wdata   (bus_wdata),
    .set_vec (cmd_hit[CK_REQ_ON]),
    .clr_vec (cmd_hit[CK_REQ_OFF]),
    .en_q    (req_en)
  );

  dcr_enable_bank #(.NCH(NCH), .AW(AW), .LO_OFF(OFF_EIE_LO), .HI_OFF(OFF_EIE_HI)) u_eie (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bus_wr),
    .waddr   (bus_addr),
    .be      (bus_be),
    .wdata   (bus_wdata),
    .set_vec (cmd_hit[CK_EIE_ON]),
    .clr_vec (cmd_hit[CK_EIE_OFF]),
    .en_q    (err_irq_en)
  );

  dcr_flag_bank #(.NCH(NCH), .AW(AW), .LO_OFF(OFF_INT_LO), .HI_OFF(OFF_INT_HI)) u_intf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bus_wr),
    .waddr   (bus_addr),
    .be      (bus_be),
    .wdata   (bus_wdata),
    .hw_set  (hw_int_set),
    .clr_cmd (cmd_hit[CK_INTF_CLR]),
    .flag_q  (int_flag)
  );

  dcr_flag_bank #(.NCH(NCH), .AW(AW), .LO_OFF(OFF_ERR_LO), .HI_OFF(OFF_ERR_HI)) u_errf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bus_wr),
    .waddr   (bus_addr),
    .be      (bus_be),
    .wdata   (bus_wdata),
    .hw_set  (hw_err_set),
    .clr_cmd (cmd_hit[CK_ERRF_CLR]),
    .flag_q  (err_flag)
  );

  // strobe registers: one cycle after the command write
  assign pulse_d   = {cmd_hit[CK_DONE_CLR], cmd_hit[CK_START],
                      cmd_hit[CK_ERRF_CLR], cmd_hit[CK_INTF_CLR]};
  assign pulse_upd = bus_wr | (|pulse_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= '0;
    end else if (pulse_upd) begin
      pulse_q <= pulse_d;
    end
  end

  assign int_clr_pulse  = pulse_q[0*NCH +: NCH];
  assign err_clr_pulse  = pulse_q[1*NCH +: NCH];
  assign start_pulse    = pulse_q[2*NCH +: NCH];
  assign done_clr_pulse = pulse_q[3*NCH +: NCH];

  // read path; high halves are zero when only 32 channels exist
  assign base  = {bus_addr, 2'b00};
  assign req_w = 64'(req_en);
  assign eie_w = 64'(err_irq_en);
  assign int_w = 64'(int_flag);
  assign err_w = 64'(err_flag);

  always_comb begin
    rdata_d = '0;
    case (base)
      AW'(OFF_REQ_LO): rdata_d = req_w[31:0];
      AW'(OFF_REQ_HI): rdata_d = req_w[63:32];
      AW'(OFF_EIE_LO): rdata_d = eie_w[31:0];
      AW'(OFF_EIE_HI): rdata_d = eie_w[63:32];
      AW'(OFF_INT_LO): rdata_d = int_w[31:0];
      AW'(OFF_INT_HI): rdata_d = int_w[63:32];
      AW'(OFF_ERR_LO): rdata_d = err_w[31:0];
      AW'(OFF_ERR_HI): rdata_d = err_w[63:32];
      default:         rdata_d = '0;
    endcase
  end

  assign bus_rdata = rdata_d;

  AST_ONE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(start_pulse)); // R9
  AST_PULSE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    ((|int_clr_pulse) && !$past(bus_wr)) |-> 1'b0); // R9
  AST_CMD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((base == AW'(OFF_CMD0)) || (base == AW'(OFF_CMD1))) |-> (bus_rdata == '0)); // R11
  AST_INT_CLR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (|int_clr_pulse) |-> ((int_flag & int_clr_pulse) == '0)); // R9

endmodule

// File: tb/tb_dma_chan_ctrl.sv
module tb_dma_chan_ctrl;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [5:0]  bus_addr;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata;
  logic [63:0] hw_int, hw_err;

  logic [31:0] rd64, rd32;
  logic [63:0] req64, eie64, pi64, pe64, ps64, pd64;
  logic [31:0] req32, eie32, pi32, pe32, ps32, pd32;

  int    n_chk = 0;
  int    n_fail = 0;
  string cur = "R13";
  bit    done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  dma_chan_ctrl #(.WIDE_LAYOUT(1'b1), .AW(8)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(rd64),
    .hw_int_set(hw_int), .hw_err_set(hw_err), .req_en(req64),
    .err_irq_en(eie64), .int_clr_pulse(pi64), .err_clr_pulse(pe64),
    .start_pulse(ps64), .done_clr_pulse(pd64));

  dma_chan_ctrl #(.WIDE_LAYOUT(1'b0), .AW(8)) dut32 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(rd32),
    .hw_int_set(hw_int[31:0]), .hw_err_set(hw_err[31:0]), .req_en(req32),
    .err_irq_en(eie32), .int_clr_pulse(pi32), .err_clr_pulse(pe32),
    .start_pulse(ps32), .done_clr_pulse(pd32));

  // reference model, index 0 = 32-channel layout, 1 = 64-channel layout
  logic [63:0] m_req [2];
  logic [63:0] m_eie [2];
  logic [63:0] m_int [2];
  logic [63:0] m_err [2];
  logic [63:0] m_pi  [2];
  logic [63:0] m_pe  [2];
  logic [63:0] m_ps  [2];
  logic [63:0] m_pd  [2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < 2; l++) begin
        m_req[l] = '0; m_eie[l] = '0; m_int[l] = '0; m_err[l] = '0;
        m_pi[l] = '0; m_pe[l] = '0; m_ps[l] = '0; m_pd[l] = '0;
      end
    end else begin
      for (int l = 0; l < 2; l++) begin
        logic [63:0] msk, ci, ce;
        int nch, base, lane, ch, k;
        logic [7:0] bv;
        msk = (l == 1) ? '1 : 64'h0000_0000_FFFF_FFFF;
        nch = (l == 1) ? 64 : 32;
        ci = '0; ce = '0;
        m_pi[l] = '0; m_pe[l] = '0; m_ps[l] = '0; m_pd[l] = '0;
        if (bus_wr) begin
          base = int'(bus_addr) * 4;
          if (base == 'h18 || base == 'h1C) begin
            if ($countones(bus_be) == 1) begin
              lane = 0;
              for (int b = 0; b < 4; b++) if (bus_be[b]) lane = b;
              ch = int'(bus_wdata[8*lane +: 8]);
              k = base - 'h18 + lane;
              if (l == 1) k = k ^ 3;
              if (ch < nch) begin
                case (k)
                  0: m_eie[l][ch] = 1'b0;
                  1: m_eie[l][ch] = 1'b1;
                  2: m_req[l][ch] = 1'b0;
                  3: m_req[l][ch] = 1'b1;
                  4: m_pd[l][ch] = 1'b1;
                  5: m_ps[l][ch] = 1'b1;
                  6: begin ce[ch] = 1'b1; m_pe[l][ch] = 1'b1; end
                  default: begin ci[ch] = 1'b1; m_pi[l][ch] = 1'b1; end
                endcase
              end
            end
          end else begin
            for (int b = 0; b < 4; b++) begin
              if (bus_be[b]) begin
                bv = bus_wdata[8*b +: 8];
                case (base)
                  'h0C: m_req[l][8*b +: 8] = bv;
                  'h08: if (l == 1) m_req[l][32+8*b +: 8] = bv;
                  'h14: m_eie[l][8*b +: 8] = bv;
                  'h10: if (l == 1) m_eie[l][32+8*b +: 8] = bv;
                  'h24: ci[8*b +: 8] = ci[8*b +: 8] | bv;
                  'h20: if (l == 1) ci[32+8*b +: 8] = ci[32+8*b +: 8] | bv;
                  'h2C: ce[8*b +: 8] = ce[8*b +: 8] | bv;
                  'h28: if (l == 1) ce[32+8*b +: 8] = ce[32+8*b +: 8] | bv;
                  default: ;
                endcase
              end
            end
          end
        end
        m_int[l] = (m_int[l] | (hw_int & msk)) & ~ci;
        m_err[l] = (m_err[l] | (hw_err & msk)) & ~ce;
      end
    end
  end

  function automatic logic [31:0] exp_rd(int l, int base);
    case (base)
      'h0C: return m_req[l][31:0];
      'h08: return m_req[l][63:32];
      'h14: return m_eie[l][31:0];
      'h10: return m_eie[l][63:32];
      'h24: return m_int[l][31:0];
      'h20: return m_int[l][63:32];
      'h2C: return m_err[l][31:0];
      'h28: return m_err[l][63:32];
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", cur, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (!done) begin
      chk("req64",  req64,  m_req[1]);
      chk("eie64",  eie64,  m_eie[1]);
      chk("pint64", pi64,   m_pi[1]);
      chk("perr64", pe64,   m_pe[1]);
      chk("pst64",  ps64,   m_ps[1]);
      chk("pdn64",  pd64,   m_pd[1]);
      chk("rd64",   64'(rd64), 64'(exp_rd(1, int'(bus_addr) * 4)));
      chk("req32",  64'(req32), m_req[0]);
      chk("eie32",  64'(eie32), m_eie[0]);
      chk("pint32", 64'(pi32),  m_pi[0]);
      chk("perr32", 64'(pe32),  m_pe[0]);
      chk("pst32",  64'(ps32),  m_ps[0]);
      chk("pdn32",  64'(pd32),  m_pd[0]);
      chk("rd32",   64'(rd32),  64'(exp_rd(0, int'(bus_addr) * 4)));
    end
  end

  task automatic report();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic wr(input int off, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 6'(off >> 2); bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = 4'h0;
  endtask

  task automatic cmd(input int off, input int ch);
    wr(off & ~3, 4'(1 << (off & 3)), 32'(ch) << (8 * (off & 3)));
  endtask

  task automatic sweep();
    for (int a = 0; a < 12; a++) begin
      @(negedge clk);
      bus_addr = 6'(a);
    end
  endtask

  task automatic hwset(input logic [63:0] i, input logic [63:0] e);
    @(negedge clk);
    hw_int = i; hw_err = e;
    @(negedge clk);
    hw_int = '0; hw_err = '0;
  endtask

  initial begin
    #(CLK_P * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_be = '0; bus_wdata = '0;
    hw_int = '0; hw_err = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur = "R13";
    sweep();

    cur = "R1";
    cmd('h18, 5); cmd('h18, 63); cmd('h1B, 31); cmd('h1B, 0);
    sweep();
    cur = "R2";
    cmd('h19, 5); cmd('h1A, 31); cmd('h1A, 0);
    sweep();
    cur = "R3";
    cmd('h1A, 40); cmd('h19, 3); cmd('h1A, 12); cmd('h1B, 40); cmd('h18, 3);
    sweep();

    cur = "R4/R5";
    wr('h0C, 4'hF, 32'hFFFF_FFFF); wr('h14, 4'hF, 32'hFFFF_FFFF);
    wr('h08, 4'hF, 32'hFFFF_FFFF); wr('h10, 4'hF, 32'hFFFF_FFFF);
    hwset('1, '1);
    for (int off = 'h18; off < 'h20; off++) cmd(off, 9);
    for (int off = 'h18; off < 'h20; off++) cmd(off, 31);
    sweep();

    cur = "R6";
    wr('h0C, 4'b0101, 32'hA5C3_9617); wr('h08, 4'b1010, 32'h1234_5678);
    wr('h14, 4'b0010, 32'h0000_3C00); wr('h10, 4'b1111, 32'hDEAD_BEEF);
    sweep();

    cur = "R7";
    hwset(64'h8000_0001_0000_8001, 64'h0000_4000_2000_0010);
    hwset(64'h0F00_0000_00F0_0000, 64'h1000_0000_0000_0001);
    sweep();

    cur = "R8";
    wr('h24, 4'b0011, 32'hFFFF_FFFF); wr('h20, 4'b1000, 32'hF000_0000);
    wr('h2C, 4'b1111, 32'h0000_0011); wr('h28, 4'b0100, 32'h0000_0000);
    sweep();

    cur = "R9";
    hwset('1, '1);
    cmd('h1C, 33); cmd('h1D, 2); cmd('h1E, 7); cmd('h1F, 20);
    cmd('h1D, 60); cmd('h1C, 0); cmd('h1E, 63); cmd('h1F, 31);
    sweep();

    cur = "R10";
    for (int off = 'h18; off < 'h20; off++) begin
      cmd(off, 64); cmd(off, 200); cmd(off, 32);
    end
    sweep();

    cur = "R11";
    wr('h18, 4'b0011, 32'h0000_0404); wr('h1C, 4'b1111, 32'h0101_0101);
    wr('h18, 4'b1001, 32'h0200_0002);
    sweep();

    cur = "R12";
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 6'('h1C >> 2); bus_be = 4'b0001; bus_wdata = 32'd7;
    hw_int = 64'h80; hw_err = 64'h80;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 6'('h24 >> 2); bus_be = 4'b0001; bus_wdata = 32'h0000_0044;
    hw_int = 64'h44; hw_err = '0;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0; hw_int = '0;
    sweep();

    repeat (2) @(negedge clk);
    report();
  end

endmodule